// File: doc/BRIEF.md
# Confidence-Gated Memory Issue Filter

This block sits between the load-store queue and the data memory port of an out-of-order core. It keeps up to eight pending memory access instructions. Each one is tagged with the program block it belongs to and with an age stamp. In every cycle it decides which of them may send a request to memory. A confidence estimator elsewhere in the core supplies a throttle block number and an enable bit. While the enable bit is set, instructions that belong to the throttle block or to any later (numerically larger) block are treated as low confidence and are held. Instructions from earlier blocks go ahead.

As branches resolve correctly, the estimator raises the throttle block number, and held entries below the new value become eligible with no further action. When a branch resolves as mispredicted, the core drives a flush with the age of that branch. Every entry with a larger age is removed, so no wrong-path request ever reaches memory. The block also reports how many live entries the throttle is currently holding, which a threshold adapter can use to tune the estimator.

Among eligible entries the block always offers the oldest one (the smallest age) on a single valid/ready issue port. Address disambiguation and store forwarding are handled elsewhere.

Top module: `mem_issue_filter`

## Requirements
- R1: While reset is asserted and directly after it, the queue is empty: mem_valid is 0, enq_ready is 1 and stall_count is 0.
- R2: When thr_ctl is 0, every live entry is eligible to issue, whatever its block ID.
- R3: When thr_ctl is 1, an entry whose block ID, compared as an unsigned number, is greater than or equal to thr_bid is held and never appears on the memory port. An entry with a smaller block ID is eligible.
- R4: A held entry becomes eligible in the first cycle in which thr_bid exceeds its block ID or thr_ctl drops, without being enqueued again.
- R5: Of the eligible entries, the one with the smallest age (unsigned) is offered on mem_bid/mem_age. An entry leaves the queue at the clock edge where mem_valid and mem_ready are both 1, at most one per cycle. With mem_ready at 0 it stays.
- R6: In a cycle with flush_valid at 1, every entry whose age is greater than flush_age is excluded from issue and from stall_count in that same cycle, and it is removed at the following edge.
- R7: An enqueue whose age is greater than flush_age, arriving in a cycle with flush_valid at 1, is discarded.
- R8: The queue holds DEPTH (8) entries. enq_ready is 0 while all slots are occupied, and an enqueue presented then is not stored. A stored entry can be offered no earlier than the cycle after its enqueue.
- R9: stall_count equals the number of live entries currently held by R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | New memory instruction presented |
| enq_ready | output | 1 | A free slot exists |
| enq_bid | input | 6 | Program block ID of the new instruction |
| enq_age | input | 6 | Age stamp of the new instruction (larger is younger) |
| thr_ctl | input | 1 | Throttling engaged |
| thr_bid | input | 6 | Throttle block ID: IDs at or above it are held |
| flush_valid | input | 1 | Misprediction flush |
| flush_age | input | 6 | Age of the mispredicted branch |
| mem_valid | output | 1 | An eligible entry is offered |
| mem_ready | input | 1 | Memory port accepts the offered entry |
| mem_bid | output | 6 | Block ID of the offered entry |
| mem_age | output | 6 | Age of the offered entry |
| stall_count | output | 4 | Live entries held by the throttle |

## Verification
A flush and an issue handshake can fall in the same cycle. So can a flush and an enqueue. The bench provokes both with one vector. That vector holds an old eligible entry, a held entry and a younger entry in the queue, and it drives flush_valid with mem_ready high and a young enqueue at the same time. The check expects the old entry on the port with the killed entry absent from stall_count. The next vector, with the throttle still engaged, must show an empty port. That proves the young entry and the discarded enqueue are both gone, while the held entry survives.

// File: rtl/mif_pkg.sv
package mif_pkg;

  // configuration of the issue filter
  localparam int unsigned MIF_DEPTH = 8;
  localparam int unsigned MIF_BID_W = 6;
  localparam int unsigned MIF_AGE_W = 6;

  // one pending memory instruction
  typedef struct packed {
    logic [MIF_BID_W-1:0] bid;
    logic [MIF_AGE_W-1:0] age;
  } mif_entry_t;

endpackage

// File: rtl/mif_slot.sv
module mif_slot
  import mif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  mif_entry_t           wr_entry,
  input  logic                 issue_clr,
  input  logic                 flush_valid,
  input  logic [MIF_AGE_W-1:0] flush_age,
  input  logic                 thr_ctl,
  input  logic [MIF_BID_W-1:0] thr_bid,
  output logic                 valid,
  output mif_entry_t           entry,
  output logic                 eligible,
  output logic                 held
);

  logic       valid_q, valid_d;
  mif_entry_t entry_q, entry_d;
  logic       kill, live, over_thr;

  // squash on a flush from an older branch
  assign kill     = valid_q && flush_valid && (entry_q.age > flush_age);
  assign live     = valid_q && !kill;
  assign over_thr = thr_ctl && (entry_q.bid >= thr_bid);
  assign held     = live && over_thr;
  assign eligible = live && !over_thr;

  always_comb begin
    valid_d = valid_q;
    entry_d = entry_q;
    if (issue_clr || kill) valid_d = 1'b0;
    if (wr_en) begin
      valid_d = 1'b1;
      entry_d = wr_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) entry_q <= entry_d;
  end

  assign valid = valid_q;
  assign entry = entry_q;

  // R6
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !valid_q);

  // R5
  issue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_clr && !wr_en) |=> !valid_q);

endmodule

// File: rtl/mif_oldest_pick.sv
module mif_oldest_pick #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AGE_W = 6,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            req,
  input  logic [DEPTH-1:0][AGE_W-1:0] age,
  output logic                        gnt_valid,
  output logic [IDX_W-1:0]            gnt_idx
);

  logic [AGE_W-1:0] best_age;

  // linear scan keeping the smallest age; ties go to the lower slot
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    best_age  = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (req[i] && (!gnt_valid || (age[i] < best_age))) begin
        gnt_valid = 1'b1;
        gnt_idx   = IDX_W'(i);
        best_age  = age[i];
      end
    end
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_order
    // R5
    oldest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && req[g]) |-> (age[gnt_idx] <= age[g]));
  end

endmodule

// File: rtl/mif_free_pick.sv
module mif_free_pick #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] used,
  output logic             free_valid,
  output logic [IDX_W-1:0] free_idx
);

  // lowest unused slot
  always_comb begin
    free_valid = 1'b0;
    free_idx   = '0;
    for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
      if (!used[i]) begin
        free_valid = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mif_popcnt.sv
module mif_popcnt #(
  parameter int unsigned N = 8,
  localparam int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits,
  output logic [CNT_W-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < int'(N); i++) begin
      count = count + CNT_W'(bits[i]);
    end
  end

endmodule

// File: rtl/mem_issue_filter.sv
module mem_issue_filter
  import mif_pkg::*;
#(
  parameter int unsigned DEPTH = MIF_DEPTH,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enq_valid,
  output logic                 enq_ready,
  input  logic [MIF_BID_W-1:0] enq_bid,
  input  logic [MIF_AGE_W-1:0] enq_age,
  input  logic                 thr_ctl,
  input  logic [MIF_BID_W-1:0] thr_bid,
  input  logic                 flush_valid,
  input  logic [MIF_AGE_W-1:0] flush_age,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [MIF_BID_W-1:0] mem_bid,
  output logic [MIF_AGE_W-1:0] mem_age,
  output logic [CNT_W-1:0]     stall_count
);

  logic [DEPTH-1:0]                slot_valid;
  logic [DEPTH-1:0]                slot_elig;
  logic [DEPTH-1:0]                slot_held;
  logic [DEPTH-1:0][MIF_AGE_W-1:0] slot_age;
  mif_entry_t                      slot_entry [DEPTH];

  logic             free_valid;
  logic [IDX_W-1:0] free_idx;
  logic             gnt_valid;
  logic [IDX_W-1:0] gnt_idx;
  logic             enq_drop;
  logic             enq_accept;
  logic             issue_fire;
  mif_entry_t       new_entry;

  // enqueue side
  assign enq_ready  = free_valid;
  assign enq_drop   = flush_valid && (enq_age > flush_age);
  assign enq_accept = enq_valid && enq_ready && !enq_drop;
  assign new_entry  = '{bid: enq_bid, age: enq_age};

  mif_free_pick #(.DEPTH(DEPTH)) i_free (
    .used       (slot_valid),
    .free_valid (free_valid),
    .free_idx   (free_idx)
  );

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    logic wr_en_s;
    logic clr_s;
    assign wr_en_s = enq_accept && (free_idx == IDX_W'(g));
    assign clr_s   = issue_fire && (gnt_idx == IDX_W'(g));

    mif_slot i_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en_s),
      .wr_entry    (new_entry),
      .issue_clr   (clr_s),
      .flush_valid (flush_valid),
      .flush_age   (flush_age),
      .thr_ctl     (thr_ctl),
      .thr_bid     (thr_bid),
      .valid       (slot_valid[g]),
      .entry       (slot_entry[g]),
      .eligible    (slot_elig[g]),
      .held        (slot_held[g])
    );

    assign slot_age[g] = slot_entry[g].age;
  end

  // issue side
  mif_oldest_pick #(.DEPTH(DEPTH), .AGE_W(MIF_AGE_W)) i_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (slot_elig),
    .age       (slot_age),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  assign mem_valid  = gnt_valid;
  assign mem_bid    = slot_entry[gnt_idx].bid;
  assign mem_age    = slot_entry[gnt_idx].age;
  assign issue_fire = gnt_valid && mem_ready;

  mif_popcnt #(.N(DEPTH)) i_cnt (
    .bits  (slot_held),
    .count (stall_count)
  );

  // R3
  throttle_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && thr_ctl) |-> (mem_bid < thr_bid));

  // R6
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && flush_valid) |-> (mem_age <= flush_age));

  // R8
  enq_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_accept && !issue_fire && !flush_valid)
      |=> ($countones(slot_valid) == $past($countones(slot_valid)) + 1));

  // R5
  issue_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && !enq_valid && !flush_valid)
      |=> ($countones(slot_valid) + 1 == $past($countones(slot_valid))));

  // R9
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stall_count) <= $countones(slot_valid));

endmodule

// File: tb/test_mem_issue_filter.sv
module test_mem_issue_filter;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic       ev;
    logic [5:0] eb;
    logic [5:0] ea;
    logic       tc;
    logic [5:0] thr;
    logic       fv;
    logic [5:0] fa;
    logic       rdy;
    logic       xv;
    logic [5:0] xa;
    logic [3:0] xs;
    logic       xr;
  } vec_t;

  // ev eb ea tc thr fv fa rdy | xv xa xs xr
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd2,  6'd1,  1'b1, 6'd5, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 4'd0, 1'b1}, // R8 fresh entry not yet visible
    '{1'b1, 6'd6,  6'd2,  1'b1, 6'd5, 1'b0, 6'd0, 1'b0, 1'b1, 6'd1, 4'd0, 1'b1}, // R3 low id eligible
    '{1'b1, 6'd5,  6'd3,  1'b1, 6'd5, 1'b0, 6'd0, 1'b0, 1'b1, 6'd1, 4'd1, 1'b1}, // R3 R9 id above thr held
    '{1'b0, 6'd0,  6'd0,  1'b1, 6'd5, 1'b0, 6'd0, 1'b1, 1'b1, 6'd1, 4'd2, 1'b1}, // R3 equal id held, R5 issue
    '{1'b0, 6'd0,  6'd0,  1'b1, 6'd5, 1'b0, 6'd0, 1'b1, 1'b0, 6'd0, 4'd2, 1'b1}, // R5 popped, rest held
    '{1'b0, 6'd0,  6'd0,  1'b1, 6'd6, 1'b0, 6'd0, 1'b0, 1'b1, 6'd3, 4'd1, 1'b1}, // R4 release by thr raise
    '{1'b0, 6'd0,  6'd0,  1'b0, 6'd6, 1'b0, 6'd0, 1'b0, 1'b1, 6'd2, 4'd0, 1'b1}, // R2 R5 throttle off, oldest
    '{1'b0, 6'd0,  6'd0,  1'b0, 6'd6, 1'b0, 6'd0, 1'b1, 1'b1, 6'd2, 4'd0, 1'b1}, // R5 stays until ready
    '{1'b1, 6'd1,  6'd9,  1'b1, 6'd3, 1'b0, 6'd0, 1'b1, 1'b0, 6'd0, 4'd1, 1'b1}, // R3 after thr lowered
    '{1'b1, 6'd1,  6'd10, 1'b1, 6'd3, 1'b0, 6'd0, 1'b0, 1'b1, 6'd9, 4'd1, 1'b1}, // R5 oldest eligible
    '{1'b1, 6'd0,  6'd11, 1'b1, 6'd3, 1'b1, 6'd9, 1'b1, 1'b1, 6'd9, 4'd1, 1'b1}, // R6 R7 flush+issue+enq
    '{1'b0, 6'd0,  6'd0,  1'b1, 6'd3, 1'b0, 6'd0, 1'b1, 1'b0, 6'd0, 4'd1, 1'b1}, // R6 R7 young gone
    '{1'b0, 6'd0,  6'd0,  1'b0, 6'd3, 1'b0, 6'd0, 1'b0, 1'b1, 6'd3, 4'd0, 1'b1}, // R2 survivor offered
    '{1'b0, 6'd0,  6'd0,  1'b1, 6'd3, 1'b1, 6'd2, 1'b1, 1'b0, 6'd0, 4'd0, 1'b1}, // R6 R9 killed not counted
    '{1'b0, 6'd0,  6'd0,  1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 1'b0, 6'd0, 4'd0, 1'b1}  // R6 removed
  };

  localparam int FILL_AGE  [8] = '{20, 13, 17, 11, 19, 15, 12, 18};
  localparam int DRAIN_AGE [8] = '{11, 12, 13, 15, 17, 18, 19, 20};

  logic       clk;
  logic       rst_n;
  logic       enq_valid;
  logic       enq_ready;
  logic [5:0] enq_bid;
  logic [5:0] enq_age;
  logic       thr_ctl;
  logic [5:0] thr_bid;
  logic       flush_valid;
  logic [5:0] flush_age;
  logic       mem_valid;
  logic       mem_ready;
  logic [5:0] mem_bid;
  logic [5:0] mem_age;
  logic [3:0] stall_count;

  int n_chk  = 0;
  int n_fail = 0;

  mem_issue_filter i_mem_issue_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_valid   (enq_valid),
    .enq_ready   (enq_ready),
    .enq_bid     (enq_bid),
    .enq_age     (enq_age),
    .thr_ctl     (thr_ctl),
    .thr_bid     (thr_bid),
    .flush_valid (flush_valid),
    .flush_age   (flush_age),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_bid     (mem_bid),
    .mem_age     (mem_age),
    .stall_count (stall_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    enq_valid   = 1'b0;
    enq_bid     = '0;
    enq_age     = '0;
    thr_ctl     = 1'b0;
    thr_bid     = '0;
    flush_valid = 1'b0;
    flush_age   = '0;
    mem_ready   = 1'b0;
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " mem_valid"}, int'(mem_valid), 0);
    chk({tag, " enq_ready"}, int'(enq_ready), 1);
    chk({tag, " stall_count"}, int'(stall_count), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    #2;
    repeat (2) @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check_reset_state("R1 after reset");

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      enq_valid   = VECS[v].ev;
      enq_bid     = VECS[v].eb;
      enq_age     = VECS[v].ea;
      thr_ctl     = VECS[v].tc;
      thr_bid     = VECS[v].thr;
      flush_valid = VECS[v].fv;
      flush_age   = VECS[v].fa;
      mem_ready   = VECS[v].rdy;
      #2;
      chk($sformatf("vec%0d mem_valid", v), int'(mem_valid), int'(VECS[v].xv));
      if (VECS[v].xv)
        chk($sformatf("vec%0d mem_age", v), int'(mem_age), int'(VECS[v].xa));
      chk($sformatf("vec%0d stall_count", v), int'(stall_count), int'(VECS[v].xs));
      chk($sformatf("vec%0d enq_ready", v), int'(enq_ready), int'(VECS[v].xr));
    end

    // R8: fill all slots with scrambled ages, block IDs 0..7
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      idle_inputs();
      enq_valid = 1'b1;
      enq_bid   = 6'(k);
      enq_age   = 6'(FILL_AGE[k]);
    end
    @(negedge clk);
    idle_inputs();
    enq_valid = 1'b1;
    enq_bid   = 6'd0;
    enq_age   = 6'd5;
    thr_ctl   = 1'b1;
    thr_bid   = 6'd0;
    #2;
    chk("R8 full enq_ready", int'(enq_ready), 0);
    chk("R9 all held", int'(stall_count), 8);
    chk("R3 nothing below thr", int'(mem_valid), 0);

    @(negedge clk);
    idle_inputs();
    thr_ctl = 1'b1;
    thr_bid = 6'd4;
    #2;
    chk("R9 half held", int'(stall_count), 4);
    chk("R5 oldest below thr valid", int'(mem_valid), 1);
    chk("R5 oldest below thr age", int'(mem_age), 11);

    // R5: drain in age order; the refused enqueue (age 5) must never show
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      idle_inputs();
      mem_ready = 1'b1;
      #2;
      chk($sformatf("R5 drain %0d valid", k), int'(mem_valid), 1);
      chk($sformatf("R5 drain %0d age", k), int'(mem_age), DRAIN_AGE[k]);
    end
    @(negedge clk);
    idle_inputs();
    mem_ready = 1'b1;
    #2;
    chk("R8 refused enq absent", int'(mem_valid), 0);
    chk("R8 empty enq_ready", int'(enq_ready), 1);

    // R1: reset in the middle of traffic
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      idle_inputs();
      enq_valid = 1'b1;
      enq_bid   = 6'd7;
      enq_age   = 6'(30 + k);
    end
    @(negedge clk);
    idle_inputs();
    thr_ctl = 1'b1;
    thr_bid = 6'd1;
    #2;
    chk("R9 before reset", int'(stall_count), 2);
    rst_n = 1'b0;
    #1;
    check_reset_state("R1 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle_inputs();
    @(negedge clk);
    #2;
    check_reset_state("R1 post mid reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule